// File: doc/BRIEF.md
# Locality Interrupt Enable and Status Unit

This unit holds, for every locality of a multi-locality command interface, an interrupt-enable word and an interrupt-status word. It drives one shared interrupt line and a pin copy of that line with the selected polarity applied. Other logic reports events as single-cycle pulses. Each pulse names a locality and any mix of four sources: data available, status valid, locality changed and command ready. This unit only decides whether an event is recorded and whether it raises the line. It does not decide when events happen.

Software reaches the words through a simple register port. A write carries a register select and a locality index, and only the locality currently marked active may change its enable or status word. A read is combinational from the select and locality inputs. Two further registers are constant. The capability word lists the supported sources. The vector word returns an interrupt number fixed by a parameter.

Top module: `lirq_unit`

## Requirements
- R1: A write to the enable register (select 0) stores only bit 31 (global enable), bits 4:3 (polarity code) and the source bits 0, 1, 2 and 7. Every other bit reads back as 0.
- R2: After reset, every locality's enable word reads 0x0000_0008 (polarity code 01, low level), every status word reads 0, and the line is low.
- R3: An event input bit maps to a status bit as follows: evt_src[0] to bit 0, [1] to bit 1, [2] to bit 2 and [3] to bit 7. That status bit is set, and the line is raised, only when the named locality has enable bit 31 set and the matching source bit set.
- R4: The status register (select 1) is write-1-to-clear for bits 0, 1, 2 and 7. The line drops in the cycle after a status write leaves a previously non-zero status at zero. Clearing only some bits, or writing 1 to bits that are already clear, leaves the line high.
- R5: A write to the enable or status register whose locality is not the active one (active_valid low, or active_loc different) changes nothing.
- R6: When an event and a status clear reach the same locality in the same cycle, the event's bit is set after the clear is applied. If the status is then non-zero, the line stays high.
- R7: The vector register (select 2) reads the parameter IRQ_NUM in bits 3:0 and zero above them. Writes to it have no effect.
- R8: The capability register (select 3) reads 0x0000_0097: the supported-source mask plus bit 4, which marks low-level support.
- R9: irq_pin is the inverted line when the active locality's polarity code is 01, or when no locality is active. Otherwise it equals the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_valid | input | 1 | A locality is currently active |
| active_loc | input | LOC_W | Index of the active locality |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 enable, 1 status, 2 vector, 3 capability) |
| wr_loc | input | LOC_W | Locality issuing the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_loc | input | LOC_W | Locality being read (an index beyond the last reads 0 for enable and status) |
| rd_data | output | 32 | Read data, combinational |
| evt_valid | input | 1 | Event pulse |
| evt_loc | input | LOC_W | Locality the event belongs to |
| evt_src | input | 4 | Sources of the event (data available, status valid, locality changed, command ready) |
| irq_line | output | 1 | Interrupt line, high when asserted |
| irq_pin | output | 1 | Interrupt line with polarity applied |

## Verification
An event pulse and a write-1-to-clear of the status word can hit the same locality in the same clock. The bench drives both strobes from a single falling edge. One case clears the bit that the event sets again; another clears a different bit. Afterwards the bench reads the status word and the line. Each case passes only if the event's bit is present and the line is still high, which shows that the set is applied after the clear.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int DW = 32;
    localparam logic [DW-1:0] SRC_MASK  = 32'h0000_0087;
    localparam logic [DW-1:0] POL_MASK  = 32'h0000_0018;
    localparam logic [DW-1:0] GLB_MASK  = 32'h8000_0000;
    localparam logic [DW-1:0] EN_WMASK  = SRC_MASK | POL_MASK | GLB_MASK;
    localparam logic [DW-1:0] EN_RESET  = 32'h0000_0008;
    localparam logic [DW-1:0] CAP_WORD  = SRC_MASK | 32'h0000_0010;
    localparam logic [1:0]    POL_LOW   = 2'b01;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_CAPS   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] st;
    } slot_t;

    // four event sources onto their status bit positions 0,1,2,7
    function automatic logic [DW-1:0] src_to_bits(input logic [3:0] s);
        return {24'd0, s[3], 4'd0, s[2], s[1], s[0]};
    endfunction
endpackage

// File: rtl/lirq_slot.sv
module lirq_slot
    import lirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          wr_st_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [DW-1:0] evt_i,
    output logic [DW-1:0] en_o,
    output logic [DW-1:0] st_o,
    output logic          raise_o,
    output logic          drop_o
);
    slot_t         slot_d, slot_q;
    logic [DW-1:0] set_bits;
    logic [DW-1:0] clr_bits;

    always_comb begin
        slot_d   = slot_q;
        set_bits = evt_i & slot_q.en & SRC_MASK & {DW{slot_q.en[DW-1]}};
        clr_bits = wr_st_i ? (wr_data_i & SRC_MASK) : '0;
        if (wr_en_i) begin
            slot_d.en = wr_data_i & EN_WMASK;
        end
        // clear first, then events: a same-cycle event wins
        slot_d.st = (slot_q.st & ~clr_bits) | set_bits;
        raise_o   = |set_bits;
        drop_o    = (|clr_bits) && (|slot_q.st) && (slot_d.st == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.en <= EN_RESET;
            slot_q.st <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign en_o = slot_q.en;
    assign st_o = slot_q.st;
endmodule

// File: rtl/lirq_line.sv
module lirq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic drop_i,
    input  logic pol_low_i,
    output logic line_o,
    output logic pin_o
);
    logic line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (drop_i) line_d = 1'b0;
        if (raise_i) line_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_d;
    end

    assign line_o = line_q;
    assign pin_o  = pol_low_i ? ~line_q : line_q;
endmodule

// File: rtl/lirq_rdmux.sv
module lirq_rdmux
    import lirq_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3,
    parameter int IRQ_NUM = 11
) (
    input  logic [NUM_LOC-1:0][DW-1:0] en_all,
    input  logic [NUM_LOC-1:0][DW-1:0] st_all,
    input  logic [1:0]                 rd_sel,
    input  logic [LOC_W-1:0]           rd_loc,
    output logic [DW-1:0]              rd_data
);
    localparam logic [DW-1:0] VEC_WORD = DW'(IRQ_NUM & 15);

    logic [DW-1:0] en_pick, st_pick;

    always_comb begin
        en_pick = '0;
        st_pick = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rd_loc == LOC_W'(i)) begin
                en_pick = en_all[i];
                st_pick = st_all[i];
            end
        end
        case (reg_sel_e'(rd_sel))
            SEL_ENABLE: rd_data = en_pick;
            SEL_STATUS: rd_data = st_pick;
            SEL_VECTOR: rd_data = VEC_WORD;
            default:    rd_data = CAP_WORD;
        endcase
    end
endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
    import lirq_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3,
    parameter int IRQ_NUM = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_valid,
    input  logic [LOC_W-1:0] active_loc,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [LOC_W-1:0] wr_loc,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_sel,
    input  logic [LOC_W-1:0] rd_loc,
    output logic [31:0]      rd_data,
    input  logic             evt_valid,
    input  logic [LOC_W-1:0] evt_loc,
    input  logic [3:0]       evt_src,
    output logic             irq_line,
    output logic             irq_pin
);
    logic [NUM_LOC-1:0][DW-1:0] en_all;
    logic [NUM_LOC-1:0][DW-1:0] st_all;
    logic [NUM_LOC-1:0]         raise_vec;
    logic [NUM_LOC-1:0]         drop_vec;
    logic                       wr_owner;
    logic                       pol_low;
    logic [DW-1:0]              evt_bits;

    assign wr_owner = wr_en && active_valid && (active_loc == wr_loc);
    assign evt_bits = src_to_bits(evt_src);

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_slot
        logic here_wr;
        assign here_wr = wr_owner && (wr_loc == LOC_W'(g));
        lirq_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (here_wr && (wr_sel == SEL_ENABLE)),
            .wr_st_i  (here_wr && (wr_sel == SEL_STATUS)),
            .wr_data_i(wr_data),
            .evt_i    ((evt_valid && evt_loc == LOC_W'(g)) ? evt_bits : '0),
            .en_o     (en_all[g]),
            .st_o     (st_all[g]),
            .raise_o  (raise_vec[g]),
            .drop_o   (drop_vec[g])
        );
    end

    always_comb begin
        pol_low = 1'b1;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (active_valid && active_loc == LOC_W'(i)) begin
                pol_low = (en_all[i][4:3] == POL_LOW);
            end
        end
    end

    lirq_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_i  (|raise_vec),
        .drop_i   (|drop_vec),
        .pol_low_i(pol_low),
        .line_o   (irq_line),
        .pin_o    (irq_pin)
    );

    lirq_rdmux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IRQ_NUM(IRQ_NUM)) u_rd (
        .en_all (en_all),
        .st_all (st_all),
        .rd_sel (rd_sel),
        .rd_loc (rd_loc),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk
    import lirq_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       active_valid,
    input logic [LOC_W-1:0]           active_loc,
    input logic                       wr_en,
    input logic [1:0]                 wr_sel,
    input logic [LOC_W-1:0]           wr_loc,
    input logic                       evt_valid,
    input logic [LOC_W-1:0]           evt_loc,
    input logic                       irq_line,
    input logic [NUM_LOC-1:0][DW-1:0] en_all,
    input logic [NUM_LOC-1:0][DW-1:0] st_all
);
    logic foreign_wr;
    assign foreign_wr = wr_en && !(active_valid && active_loc == wr_loc);

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_line) |-> $past(evt_valid)); // R3

    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_line) |-> $past(wr_en && wr_sel == SEL_STATUS)); // R4

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_chk
        AST_ENABLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[g] & ~EN_WMASK) == '0); // R1

        AST_FOREIGN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (foreign_wr && wr_sel == SEL_ENABLE && wr_loc == LOC_W'(g))
            |=> $stable(en_all[g])); // R5

        AST_FOREIGN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            (foreign_wr && wr_sel == SEL_STATUS && wr_loc == LOC_W'(g)
             && !(evt_valid && evt_loc == LOC_W'(g)))
            |=> $stable(st_all[g])); // R5
    end
endmodule

bind lirq_unit lirq_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_valid(active_valid),
    .active_loc  (active_loc),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_loc      (wr_loc),
    .evt_valid   (evt_valid),
    .evt_loc     (evt_loc),
    .irq_line    (irq_line),
    .en_all      (en_all),
    .st_all      (st_all)
);

// File: tb/lirq_unit_test.sv
module lirq_unit_test;
    localparam int NUM_LOC = 5;
    localparam int LOC_W   = 3;
    localparam int IRQ_NUM = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             active_valid = 1'b0;
    logic [LOC_W-1:0] active_loc = '0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [LOC_W-1:0] wr_loc = '0;
    logic [31:0]      wr_data = '0;
    logic [1:0]       rd_sel = '0;
    logic [LOC_W-1:0] rd_loc = '0;
    logic [31:0]      rd_data;
    logic             evt_valid = 1'b0;
    logic [LOC_W-1:0] evt_loc = '0;
    logic [3:0]       evt_src = '0;
    logic             irq_line;
    logic             irq_pin;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    lirq_unit #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IRQ_NUM(IRQ_NUM)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input int loc, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_loc = LOC_W'(loc); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, input int loc, output logic [31:0] d);
        rd_sel = sel; rd_loc = LOC_W'(loc);
        #1 d = rd_data;
    endtask

    task automatic fire(input int loc, input logic [3:0] src);
        @(negedge clk);
        evt_valid = 1'b1; evt_loc = LOC_W'(loc); evt_src = src;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic set_active(input int loc);
        @(negedge clk);
        active_valid = 1'b1; active_loc = LOC_W'(loc);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int i = 0; i < NUM_LOC; i++) begin
            reg_rd(2'd0, i, d); check("R2 enable reset", d, 32'h8);
            reg_rd(2'd1, i, d); check("R2 status reset", d, 32'h0);
        end
        check("R2 line reset", {31'd0, irq_line}, 32'd0);
        check("R9 pin idle inverted", {31'd0, irq_pin}, 32'd1);
        reg_rd(2'd3, 0, d); check("R8 capability", d, 32'h97);
        reg_rd(2'd2, 0, d); check("R7 vector", d, 32'(IRQ_NUM));
    endtask

    task automatic t_enable_mask;
        logic [31:0] d;
        set_active(1);
        reg_wr(2'd0, 1, 32'hFFFF_FFFF);
        reg_rd(2'd0, 1, d); check("R1 enable mask", d, 32'h8000_009F);
        reg_wr(2'd0, 1, 32'h0000_0008);
    endtask

    task automatic t_gating;
        logic [31:0] d;
        reg_wr(2'd0, 1, 32'h0000_0087);           // sources on, global off
        fire(1, 4'hF);
        reg_rd(2'd1, 1, d); check("R3 no global no status", d, 32'h0);
        check("R3 no global no line", {31'd0, irq_line}, 32'd0);
        reg_wr(2'd0, 1, 32'h8000_0080);           // global + command-ready only
        fire(1, 4'hF);
        reg_rd(2'd1, 1, d); check("R3 only enabled source bit7", d, 32'h80);
        check("R3 line raised", {31'd0, irq_line}, 32'd1);
        reg_wr(2'd1, 1, 32'h80);
        check("R4 line dropped after clear", {31'd0, irq_line}, 32'd0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        reg_wr(2'd0, 1, 32'h8000_0007);
        fire(1, 4'b0011);
        reg_rd(2'd1, 1, d); check("R4 two bits set", d, 32'h3);
        reg_wr(2'd1, 1, 32'h84);                  // bits not set
        reg_rd(2'd1, 1, d); check("R4 clear of unset bits", d, 32'h3);
        check("R4 line kept", {31'd0, irq_line}, 32'd1);
        reg_wr(2'd1, 1, 32'h1);
        reg_rd(2'd1, 1, d); check("R4 partial clear", d, 32'h2);
        check("R4 line kept after partial", {31'd0, irq_line}, 32'd1);
        reg_wr(2'd1, 1, 32'hFFFF_FFFF);
        reg_rd(2'd1, 1, d); check("R4 full clear", d, 32'h0);
        check("R4 line low", {31'd0, irq_line}, 32'd0);
    endtask

    task automatic t_foreign;
        logic [31:0] d;
        set_active(2);
        reg_wr(2'd0, 2, 32'h8000_0009);
        fire(2, 4'b0001);
        set_active(1);
        reg_wr(2'd0, 2, 32'hFFFF_FFFF);
        reg_rd(2'd0, 2, d); check("R5 foreign enable write", d, 32'h8000_0009);
        reg_wr(2'd1, 2, 32'h1);
        reg_rd(2'd1, 2, d); check("R5 foreign status write", d, 32'h1);
        check("R5 line kept", {31'd0, irq_line}, 32'd1);
        @(negedge clk); active_valid = 1'b0;
        reg_wr(2'd1, 2, 32'h1);
        reg_rd(2'd1, 2, d); check("R5 no active write", d, 32'h1);
        set_active(2);
        reg_wr(2'd1, 2, 32'h1);
        check("R4 owner clears", {31'd0, irq_line}, 32'd0);
    endtask

    task automatic t_vector;
        logic [31:0] d;
        set_active(1);
        reg_wr(2'd2, 1, 32'h0);
        reg_rd(2'd2, 1, d); check("R7 vector write ignored", d, 32'(IRQ_NUM));
        reg_wr(2'd3, 1, 32'h0);
        reg_rd(2'd3, 1, d); check("R8 capability write ignored", d, 32'h97);
    endtask

    task automatic t_polarity;
        reg_wr(2'd0, 1, 32'h8000_0001);           // polarity 00, active high
        fire(1, 4'b0001);
        check("R9 pin high mode", {31'd0, irq_pin}, 32'd1);
        reg_wr(2'd0, 1, 32'h8000_0009);           // polarity 01, low level
        check("R9 pin low mode", {31'd0, irq_pin}, 32'd0);
        reg_wr(2'd1, 1, 32'h1);
        check("R9 pin low mode idle", {31'd0, irq_pin}, 32'd1);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        reg_wr(2'd0, 1, 32'h8000_0003);
        fire(1, 4'b0001);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_loc = 3'd1; wr_data = 32'h1;
        evt_valid = 1'b1; evt_loc = 3'd1; evt_src = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; evt_valid = 1'b0;
        reg_rd(2'd1, 1, d); check("R6 event beats clear", d, 32'h1);
        check("R6 line stays", {31'd0, irq_line}, 32'd1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_loc = 3'd1; wr_data = 32'h1;
        evt_valid = 1'b1; evt_loc = 3'd1; evt_src = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; evt_valid = 1'b0;
        reg_rd(2'd1, 1, d); check("R6 other bit set while clearing", d, 32'h2);
        check("R6 line stays high", {31'd0, irq_line}, 32'd1);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_mask();
        t_gating();
        t_w1c();
        t_foreign();
        t_vector();
        t_polarity();
        t_collide();
        finish_run();
    end
endmodule